// File: doc/BRIEF.md
# Accumulator ALU with Status Word

This block is the arithmetic and logic core of a small accumulator machine. It combines the accumulator with an operand under a 4-bit operation code and returns the result in the same cycle. When the execute strobe is high, a status register captures four condition flags on the clock edge: overflow, negative, zero and carry. The flags share one status word with four sense-switch bits, which are driven from outside the block.

Every status bit is addressed by its one-hot weight rather than by an index. A toggle strobe flips the condition flags selected by a mask, and a combinational test output reports whether any bit selected by the operand is set, sense switches included. The multiply, divide and bitwise/shift groups are separate options, each enabled by a parameter. The divider can be built as an unrolled restoring array or as a plain operator.

Top module: `acc_alu_unit`

## Requirements
- R1: While rst_n is low the condition flags are held at zero, so status_word equals {sw_in, 4'b0000}.
- R2: status_word bit 7..4 mirror sw_in[3..0] with no delay (sw_in[3] at weight 0x80, sw_in[0] at 0x10). Bits 3..0 hold O (0x08), N (0x04), Z (0x02) and C (0x01).
- R3: Code 0x0 (add) returns (acc+opnd) mod 256. C is set on unsigned carry-out and O on two's-complement overflow.
- R4: Code 0x1 (subtract) returns (acc-opnd) mod 256. C is set when acc >= opnd unsigned (no borrow) and O on signed overflow.
- R5: Code 0x2 (multiply) returns the low byte of acc*opnd. C is set when the high byte is nonzero and O is cleared.
- R6: Code 0x3 (divide) returns acc/opnd with C and O cleared. A zero divisor returns 0xFF with O set and C cleared.
- R7: Code 0x4 returns ~opnd, 0x5 acc&opnd, 0x6 acc|opnd and 0x7 acc^opnd. C and O are cleared.
- R8: Code 0x8 rotates acc left and 0x9 rotates it right by one bit with wrap-around. Code 0xA shifts left with a zero fill and 0xB shifts right keeping bit 7. In all four C receives the bit moved out of the end and O is cleared.
- R9: For every supported code, N equals result bit 7 and Z is set when the result is zero. Flags load on the clock edge where exec is high and are visible in the next cycle.
- R10: When flag_tgl is high and exec is low, the edge XORs opnd[3:0] into the flags. opnd[7:4] has no effect, so the switch bits never change. exec wins when both strobes are high.
- R11: flag_hit is high exactly when status_word & opnd is nonzero.
- R12: With neither strobe high the flags hold. Codes 0xC-0xF return acc unchanged and leave the flags unchanged even with exec high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset of the flags |
| exec | input | 1 | Load the flags produced by the current operation |
| flag_tgl | input | 1 | Toggle the flags selected by opnd[3:0] |
| op_code | input | 4 | Operation select |
| acc | input | 8 | Accumulator value |
| opnd | input | 8 | Operand, also the bit mask for toggle and test |
| sw_in | input | 4 | Sense switches, sw_in[3] is the highest-weight bit |
| result | output | 8 | Combinational result |
| status_word | output | 8 | Switches and condition flags |
| flag_hit | output | 1 | Any status bit selected by opnd is set |

## Verification
The bench aims at the edges where flags are easy to get wrong. These include add into and out of the sign bit, subtract with and without borrow, and a multiply whose product lands exactly on 0x100. A swapped carry sense or a wrong overflow equation shows up as a flipped C or O on these vectors. Divide by zero and the shift carry-out catch a divider that returns its raw quotient and a shifter that puts the wrong end bit into C. Toggling with an all-ones mask, exec and toggle on the same edge, and reserved codes check that switch bits are never written, that exec takes priority, and that unused codes do not disturb the flags. Random operands weighted toward 0x00, 0x7F, 0x80 and 0xFF are compared with a reference model kept in the bench.

// File: rtl/aalu_pkg.sv
package aalu_pkg;

   localparam int FLAG_N = 4;

   typedef enum logic [3:0] {
      OP_ADD = 4'h0,
      OP_SUB = 4'h1,
      OP_MUL = 4'h2,
      OP_DIV = 4'h3,
      OP_NOT = 4'h4,
      OP_AND = 4'h5,
      OP_OR  = 4'h6,
      OP_XOR = 4'h7,
      OP_ROL = 4'h8,
      OP_ROR = 4'h9,
      OP_SHL = 4'hA,
      OP_SHR = 4'hB,
      OP_RSC = 4'hC,
      OP_RSD = 4'hD,
      OP_RSE = 4'hE,
      OP_RSF = 4'hF
   } alu_op_e;

   // packed order gives the bit weights 0x08, 0x04, 0x02, 0x01
   typedef struct packed {
      logic ovf;
      logic neg;
      logic zero;
      logic carry;
   } flags_t;

endpackage

// File: rtl/aalu_arith.sv
module aalu_arith
   import aalu_pkg::*;
#(
   parameter int DATA_W    = 8,
   parameter bit MUL_EN    = 1'b1,
   parameter bit DIV_EN    = 1'b1,
   parameter bit DIV_ARRAY = 1'b1
) (
   input  alu_op_e           op,
   input  logic [DATA_W-1:0] a,
   input  logic [DATA_W-1:0] b,
   output logic [DATA_W-1:0] res,
   output logic              carry,
   output logic              ovf,
   output logic              hit
);

   localparam int MSB    = DATA_W - 1;
   localparam int PROD_W = 2 * DATA_W;

   logic [DATA_W:0]   sum_w;
   logic [DATA_W:0]   dif_w;
   logic [PROD_W-1:0] prod;
   logic [DATA_W-1:0] quo;
   logic              mul_ok;
   logic              div_ok;
   logic              div_zero;

   assign sum_w    = {1'b0, a} + {1'b0, b};
   assign dif_w    = {1'b0, a} - {1'b0, b};
   assign div_zero = (b == '0);

   generate
      if (MUL_EN) begin : g_mul
         assign prod   = PROD_W'(a) * PROD_W'(b);
         assign mul_ok = 1'b1;
      end else begin : g_nomul
         assign prod   = '0;
         assign mul_ok = 1'b0;
      end
   endgenerate

   generate
      if (DIV_EN && DIV_ARRAY) begin : g_div_arr
         // restoring divider, one compare-subtract stage per quotient bit
         always_comb begin
            logic [DATA_W:0] rem;
            rem = '0;
            quo = '0;
            for (int i = MSB; i >= 0; i--) begin
               rem = {rem[DATA_W-1:0], a[i]};
               if (rem >= {1'b0, b}) begin
                  rem    = rem - {1'b0, b};
                  quo[i] = 1'b1;
               end
            end
         end
         assign div_ok = 1'b1;
      end else if (DIV_EN) begin : g_div_op
         assign quo    = div_zero ? '0 : (a / b);
         assign div_ok = 1'b1;
      end else begin : g_nodiv
         assign quo    = '0;
         assign div_ok = 1'b0;
      end
   endgenerate

   always_comb begin
      res   = a;
      carry = 1'b0;
      ovf   = 1'b0;
      hit   = 1'b0;
      unique case (op)
         OP_ADD: begin
            res   = sum_w[MSB:0];
            carry = sum_w[DATA_W];
            ovf   = (a[MSB] == b[MSB]) && (sum_w[MSB] != a[MSB]);
            hit   = 1'b1;
         end
         OP_SUB: begin
            res   = dif_w[MSB:0];
            carry = ~dif_w[DATA_W];
            ovf   = (a[MSB] != b[MSB]) && (dif_w[MSB] != a[MSB]);
            hit   = 1'b1;
         end
         OP_MUL: begin
            if (mul_ok) begin
               res   = prod[MSB:0];
               carry = |prod[PROD_W-1:DATA_W];
               hit   = 1'b1;
            end
         end
         OP_DIV: begin
            if (div_ok) begin
               res = div_zero ? '1 : quo;
               ovf = div_zero;
               hit = 1'b1;
            end
         end
         default: begin
            hit = 1'b0;
         end
      endcase
   end

endmodule

// File: rtl/aalu_bitops.sv
module aalu_bitops
   import aalu_pkg::*;
#(
   parameter int DATA_W = 8,
   parameter bit BIT_EN = 1'b1
) (
   input  alu_op_e           op,
   input  logic [DATA_W-1:0] a,
   input  logic [DATA_W-1:0] b,
   output logic [DATA_W-1:0] res,
   output logic              carry,
   output logic              hit
);

   localparam int MSB = DATA_W - 1;

   logic [DATA_W-1:0] lg_res;
   logic [DATA_W-1:0] sh_res;
   logic              sh_cy;
   logic              lg_hit;
   logic              sh_hit;

   always_comb begin
      lg_res = a;
      lg_hit = 1'b1;
      unique case (op)
         OP_NOT:  lg_res = ~b;
         OP_AND:  lg_res = a & b;
         OP_OR:   lg_res = a | b;
         OP_XOR:  lg_res = a ^ b;
         default: lg_hit = 1'b0;
      endcase
   end

   always_comb begin
      sh_res = a;
      sh_cy  = 1'b0;
      sh_hit = 1'b1;
      unique case (op)
         OP_ROL: begin
            sh_res = {a[MSB-1:0], a[MSB]};
            sh_cy  = a[MSB];
         end
         OP_ROR: begin
            sh_res = {a[0], a[MSB:1]};
            sh_cy  = a[0];
         end
         OP_SHL: begin
            sh_res = {a[MSB-1:0], 1'b0};
            sh_cy  = a[MSB];
         end
         OP_SHR: begin
            sh_res = {a[MSB], a[MSB:1]};
            sh_cy  = a[0];
         end
         default: sh_hit = 1'b0;
      endcase
   end

   generate
      if (BIT_EN) begin : g_bits
         always_comb begin
            if (lg_hit) begin
               res   = lg_res;
               carry = 1'b0;
               hit   = 1'b1;
            end else if (sh_hit) begin
               res   = sh_res;
               carry = sh_cy;
               hit   = 1'b1;
            end else begin
               res   = a;
               carry = 1'b0;
               hit   = 1'b0;
            end
         end
      end else begin : g_nobits
         assign res   = a;
         assign carry = 1'b0;
         assign hit   = 1'b0;
      end
   endgenerate

endmodule

// File: rtl/aalu_status.sv
module aalu_status
   import aalu_pkg::*;
#(
   parameter int DATA_W = 8
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     load,
   input  flags_t                   flags_in,
   input  logic                     tgl,
   input  logic [FLAG_N-1:0]        mask,
   input  logic [DATA_W-FLAG_N-1:0] sw,
   output logic [DATA_W-1:0]        status
);

   localparam int SW_N = DATA_W - FLAG_N;

   flags_t flags_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         flags_q <= '0;
      end else if (load) begin
         flags_q <= flags_in;
      end else if (tgl) begin
         flags_q <= flags_q ^ flags_t'(mask);
      end
   end

   assign status = {sw[SW_N-1:0], flags_q};

   AST_TGL_XOR: assert property (@(posedge clk) disable iff (!rst_n)
      (tgl && !load) |=> (flags_q == ($past(flags_q) ^ flags_t'($past(mask))))); // R10

   AST_FLAGS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!tgl && !load) |=> $stable(flags_q)); // R12

endmodule

// File: rtl/acc_alu_unit.sv
module acc_alu_unit
   import aalu_pkg::*;
#(
   parameter int DATA_W    = 8,
   parameter bit MUL_EN    = 1'b1,
   parameter bit DIV_EN    = 1'b1,
   parameter bit DIV_ARRAY = 1'b1,
   parameter bit BIT_EN    = 1'b1
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     exec,
   input  logic                     flag_tgl,
   input  logic [3:0]               op_code,
   input  logic [DATA_W-1:0]        acc,
   input  logic [DATA_W-1:0]        opnd,
   input  logic [DATA_W-FLAG_N-1:0] sw_in,
   output logic [DATA_W-1:0]        result,
   output logic [DATA_W-1:0]        status_word,
   output logic                     flag_hit
);

   localparam int MSB  = DATA_W - 1;
   localparam int SW_N = DATA_W - FLAG_N;

   generate
      if (SW_N < 1) begin : g_bad_width
         $error("acc_alu_unit: DATA_W must leave room for at least one switch bit");
      end
      if (DATA_W < 2) begin : g_bad_shift
         $error("acc_alu_unit: shifts need DATA_W of two or more");
      end
   endgenerate

   alu_op_e           op;
   logic [DATA_W-1:0] ar_res;
   logic              ar_cy;
   logic              ar_ovf;
   logic              ar_hit;
   logic [DATA_W-1:0] bt_res;
   logic              bt_cy;
   logic              bt_hit;
   logic              supported;
   flags_t            nxt_flags;

   assign op = alu_op_e'(op_code);

   aalu_arith #(
      .DATA_W    (DATA_W),
      .MUL_EN    (MUL_EN),
      .DIV_EN    (DIV_EN),
      .DIV_ARRAY (DIV_ARRAY)
   ) u_arith (
      .op    (op),
      .a     (acc),
      .b     (opnd),
      .res   (ar_res),
      .carry (ar_cy),
      .ovf   (ar_ovf),
      .hit   (ar_hit)
   );

   aalu_bitops #(
      .DATA_W (DATA_W),
      .BIT_EN (BIT_EN)
   ) u_bitops (
      .op    (op),
      .a     (acc),
      .b     (opnd),
      .res   (bt_res),
      .carry (bt_cy),
      .hit   (bt_hit)
   );

   assign supported = ar_hit | bt_hit;

   always_comb begin
      if (ar_hit) begin
         result          = ar_res;
         nxt_flags.carry = ar_cy;
         nxt_flags.ovf   = ar_ovf;
      end else if (bt_hit) begin
         result          = bt_res;
         nxt_flags.carry = bt_cy;
         nxt_flags.ovf   = 1'b0;
      end else begin
         result          = acc;
         nxt_flags.carry = 1'b0;
         nxt_flags.ovf   = 1'b0;
      end
      nxt_flags.neg  = result[MSB];
      nxt_flags.zero = (result == '0);
   end

   aalu_status #(
      .DATA_W (DATA_W)
   ) u_status (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (exec && supported),
      .flags_in (nxt_flags),
      .tgl      (flag_tgl),
      .mask     (opnd[FLAG_N-1:0]),
      .sw       (sw_in),
      .status   (status_word)
   );

   assign flag_hit = |(status_word & opnd);

   AST_ZERO_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
      (exec && supported) |=> (status_word[1] == ($past(result) == '0))); // R9

   AST_NEG_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
      (exec && supported) |=> (status_word[2] == $past(result[MSB]))); // R9

   AST_DIV_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (DIV_EN && op == OP_DIV && opnd == '0) |-> (result == '1 && ar_ovf && !ar_cy)); // R6

   AST_LOGIC_NO_CARRY: assert property (@(posedge clk) disable iff (!rst_n)
      (exec && BIT_EN && op_code[3:2] == 2'b01) |=> (status_word[3] == 1'b0 && status_word[0] == 1'b0)); // R7

   AST_RESERVED_PASS: assert property (@(posedge clk) disable iff (!rst_n)
      (op_code[3:2] == 2'b11) |-> (result == acc && !supported)); // R12

endmodule

// File: tb/acc_alu_unit_test.sv
module acc_alu_unit_test;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       exec = 1'b0;
   logic       flag_tgl = 1'b0;
   logic [3:0] op_code = 4'h0;
   logic [7:0] acc = 8'h00;
   logic [7:0] opnd = 8'h00;
   logic [3:0] sw_in = 4'h0;
   logic [7:0] result;
   logic [7:0] status_word;
   logic       flag_hit;

   int total = 0;
   int bad = 0;
   logic [3:0] cur_flags = 4'h0;

   always #5 clk = ~clk;

   acc_alu_unit uut (
      .clk         (clk),
      .rst_n       (rst_n),
      .exec        (exec),
      .flag_tgl    (flag_tgl),
      .op_code     (op_code),
      .acc         (acc),
      .opnd        (opnd),
      .sw_in       (sw_in),
      .result      (result),
      .status_word (status_word),
      .flag_hit    (flag_hit)
   );

   // {op, a, b, result, O N Z C}
   localparam logic [31:0] VEC [19] = '{
      {4'h0, 8'h7F, 8'h01, 8'h80, 4'b1100},
      {4'h0, 8'hFF, 8'h01, 8'h00, 4'b0011},
      {4'h0, 8'h80, 8'h80, 8'h00, 4'b1011},
      {4'h1, 8'h00, 8'h01, 8'hFF, 4'b0100},
      {4'h1, 8'h80, 8'h01, 8'h7F, 4'b1001},
      {4'h1, 8'h05, 8'h05, 8'h00, 4'b0011},
      {4'h2, 8'h10, 8'h10, 8'h00, 4'b0011},
      {4'h2, 8'h0F, 8'h0F, 8'hE1, 4'b0100},
      {4'h3, 8'hFF, 8'h10, 8'h0F, 4'b0000},
      {4'h3, 8'h7F, 8'h00, 8'hFF, 4'b1100},
      {4'h4, 8'h12, 8'hFF, 8'h00, 4'b0010},
      {4'h5, 8'hF0, 8'h3C, 8'h30, 4'b0000},
      {4'h6, 8'h00, 8'h00, 8'h00, 4'b0010},
      {4'h7, 8'hFF, 8'h7F, 8'h80, 4'b0100},
      {4'h8, 8'h81, 8'h00, 8'h03, 4'b0001},
      {4'h9, 8'h01, 8'h00, 8'h80, 4'b0101},
      {4'hA, 8'hC0, 8'h00, 8'h80, 4'b0101},
      {4'hB, 8'h81, 8'h00, 8'hC0, 4'b0101},
      {4'hB, 8'h02, 8'h00, 8'h01, 4'b0000}
   };

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s: actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic finish_run();
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   endtask

   // independent reference: {supported, result, O, N, Z, C}
   function automatic logic [12:0] ref_calc(input logic [3:0] op, input logic [7:0] a, input logic [7:0] b);
      int ia = int'(a);
      int ib = int'(b);
      int sa = int'($signed(a));
      int sb = int'($signed(b));
      int t;
      logic [7:0] r = a;
      logic o = 1'b0;
      logic c = 1'b0;
      logic ok = 1'b1;
      case (op)
         4'h0: begin t = ia + ib; r = t[7:0]; c = (t > 255); o = (sa + sb > 127) || (sa + sb < -128); end
         4'h1: begin t = ia - ib; r = t[7:0]; c = (ia >= ib); o = (sa - sb > 127) || (sa - sb < -128); end
         4'h2: begin t = ia * ib; r = t[7:0]; c = (t > 255); end
         4'h3: begin if (ib == 0) begin r = 8'hFF; o = 1'b1; end else begin t = ia / ib; r = t[7:0]; end end
         4'h4: r = ~b;
         4'h5: r = a & b;
         4'h6: r = a | b;
         4'h7: r = a ^ b;
         4'h8: begin r = {a[6:0], a[7]}; c = a[7]; end
         4'h9: begin r = {a[0], a[7:1]}; c = a[0]; end
         4'hA: begin r = {a[6:0], 1'b0}; c = a[7]; end
         4'hB: begin r = {a[7], a[7:1]}; c = a[0]; end
         default: ok = 1'b0;
      endcase
      return {ok, r, o, r[7], (r == 8'h00), c};
   endfunction

   task automatic run_op(input string req, input logic [3:0] op, input logic [7:0] a,
                         input logic [7:0] b, input logic [7:0] er, input logic [3:0] ef);
      @(negedge clk);
      op_code = op; acc = a; opnd = b; exec = 1'b1;
      #1 chk({req, " result"}, {24'h0, result}, {24'h0, er});
      @(negedge clk);
      exec = 1'b0;
      #1 chk({req, " flags"}, {28'h0, status_word[3:0]}, {28'h0, ef});
      cur_flags = status_word[3:0];
   endtask

   function automatic logic [7:0] pick(input int sel);
      case (sel % 6)
         0: return 8'h00;
         1: return 8'h7F;
         2: return 8'h80;
         3: return 8'hFF;
         default: return 8'($urandom);
      endcase
   endfunction

   initial begin
      repeat (100000) @(posedge clk);
      total++; bad++;
      $display("FAIL watchdog: actual=hung expected=done");
      finish_run();
   end

   initial begin
      // R1: reset state
      sw_in = 4'h5; exec = 1'b1; op_code = 4'h0; acc = 8'h80; opnd = 8'h80;
      repeat (3) @(negedge clk);
      #1 chk("R1 reset status", {24'h0, status_word}, 32'h50);
      exec = 1'b0;
      @(negedge clk); rst_n = 1'b1;
      // R2: switch mirror
      sw_in = 4'h9;
      #1 chk("R2 switch bits", {28'h0, status_word[7:4]}, 32'h9);
      sw_in = 4'hA;

      // table walk (R3 R4 R5 R6 R7 R8 R9)
      foreach (VEC[i]) begin
         run_op("R3-8/R9 vector", VEC[i][31:28], VEC[i][27:20], VEC[i][19:12],
                VEC[i][11:4], VEC[i][3:0]);
      end

      // random + corner values against reference model (R9)
      for (int k = 0; k < 300; k++) begin
         logic [3:0]  rop = 4'($urandom_range(0, 11));
         logic [7:0]  ra  = pick(int'($urandom_range(0, 11)));
         logic [7:0]  rb  = pick(int'($urandom_range(0, 11)));
         logic [12:0] e   = ref_calc(rop, ra, rb);
         run_op("R9 random", rop, ra, rb, e[11:4], e[3:0]);
      end

      // R2 switch bits still mirrored
      #1 chk("R2 switch after ops", {28'h0, status_word[7:4]}, 32'hA);

      // R10 toggle: known flags 0101 from ASR 0x81
      run_op("R8 asr setup", 4'hB, 8'h81, 8'h00, 8'hC0, 4'b0101);
      @(negedge clk);
      flag_tgl = 1'b1; opnd = 8'hF6;
      @(negedge clk);
      flag_tgl = 1'b0;
      #1 chk("R10 toggle flags", {28'h0, status_word[3:0]}, 32'h3);
      chk("R10 switch untouched", {28'h0, status_word[7:4]}, 32'hA);

      // R11 flag test by mask (status = 0xA3)
      opnd = 8'h04;
      #1 chk("R11 test clear bit", {31'h0, flag_hit}, 32'h0);
      opnd = 8'h02;
      #1 chk("R11 test flag bit", {31'h0, flag_hit}, 32'h1);
      opnd = 8'h40;
      #1 chk("R11 test switch clear", {31'h0, flag_hit}, 32'h0);
      opnd = 8'h80;
      #1 chk("R11 test switch set", {31'h0, flag_hit}, 32'h1);

      // R10 exec has priority over toggle: ADD 1+1 = 2, flags 0000
      @(negedge clk);
      op_code = 4'h0; acc = 8'h01; opnd = 8'h01; exec = 1'b1; flag_tgl = 1'b1;
      @(negedge clk);
      exec = 1'b0; flag_tgl = 1'b0;
      #1 chk("R10 exec priority", {28'h0, status_word[3:0]}, 32'h0);

      // R12 hold without strobes
      run_op("R12 setup", 4'h1, 8'h00, 8'h01, 8'hFF, 4'b0100);
      op_code = 4'h2; acc = 8'hFF; opnd = 8'hFF;
      repeat (3) @(negedge clk);
      #1 chk("R12 hold", {28'h0, status_word[3:0]}, 32'h4);

      // R12 reserved codes pass acc, flags unchanged
      for (int c = 12; c < 16; c++) begin
         @(negedge clk);
         op_code = 4'(c); acc = 8'h00; opnd = 8'h5A; exec = 1'b1;
         #1 chk("R12 reserved result", {24'h0, result}, 32'h00);
         @(negedge clk);
         exec = 1'b0;
         #1 chk("R12 reserved flags", {28'h0, status_word[3:0]}, 32'h4);
      end

      finish_run();
   end

endmodule